// File: doc/BRIEF.md
# Eight-Decade Decimal Counter with Snapshot Latches

This block is a synchronous decimal up-counter of eight BCD digits. It counts the falling edges of an external pulse input. It also keeps a sticky overflow flag and a bank of holding registers. The pulse input and the overflow source are asynchronous. Each passes through a two-flop synchronizer and is edge-detected in the system clock domain. A falling edge is a registered high sample followed by a low sample. The counter steps once per detected edge. The carry ripples through all decades in the same clock cycle, so 99999999 turns over to 00000000 in one step.

The counter is cleared by a level-sensitive active-low clear input, which also clears the overflow flag. The holding registers follow the live count and the overflow flag while the active-low snapshot input is low, and they freeze when it returns high. The weight-8 bits of the three most significant decades leave the block, so that a board can wire one of them back to the overflow source and shorten the usable range.

The digit count is a parameter with a default of eight and a minimum of three. The three taps always come from the three top decades.

Top module: `decade_latch_counter`

## Requirements
- R1: While `rst` is high, the count, the overflow flag, `snap_bcd`, `snap_ovf` and `top_msb` are all zero at the next clock edge.
- R2: Each falling edge on `cnt_in` adds one to the count, which is held as decimal digits. Digit k occupies bits [4k+3:4k], and digit 0 is the least significant.
- R3: A digit at 9 that receives a carry becomes 0 and passes the carry on within the same cycle, so all nines turn over to all zeros.
- R4: While `clr_n` is low, the count and the overflow flag become zero. When a count edge falls in the same cycle, the clear wins.
- R5: While `load_n` is low, `snap_bcd` takes the count every cycle. While `load_n` is high, `snap_bcd` does not change.
- R6: A falling edge on `ovf_in` sets the overflow flag. The flag stays set through further overflow activity until `clr_n` goes low.
- R7: `snap_ovf` takes the overflow flag only while `load_n` is low. Otherwise it holds.
- R8: `top_msb[0]`, `top_msb[1]` and `top_msb[2]` are bit 3 of the third-highest, second-highest and highest digit respectively.
- R9: A rising edge on `cnt_in` has no effect, and a low level held for many cycles counts exactly once.
- R10: When a snapshot and a count edge fall in the same cycle, `snap_bcd` receives the value from before the increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_in | input | 1 | Asynchronous count pulse; falling edges count |
| clr_n | input | 1 | Active-low clear of the count and the overflow flag |
| load_n | input | 1 | Active-low snapshot enable |
| ovf_in | input | 1 | Asynchronous overflow source; falling edge sets the flag |
| snap_bcd | output | 4*NUM_DIGITS | Held BCD digits |
| snap_ovf | output | 1 | Held overflow flag |
| top_msb | output | 3 | Weight-8 bits of the top three decades |

## Verification
Some rules are checked by the assertions on every cycle:
- the count changes only on a detected edge and is cleared under clear;
- the snapshot holds or copies according to `load_n`;
- the overflow flag is sticky.

Other behaviour depends on particular sequences, so only the bench scenarios can show it:
- the decimal turnover of each digit and the full wrap, which the bench exercises on a three-digit instance;
- the once-only count of a long low pulse;
- the priority of clear over a count edge in the same cycle;
- the pre-increment capture when a snapshot and a count edge coincide.

// File: rtl/dlc_pkg.sv
package dlc_pkg;
  localparam int DIGIT_W = 4;
  typedef logic [DIGIT_W-1:0] digit_t;
  localparam digit_t DIGIT_MAX = 4'd9;
endpackage

// File: rtl/dlc_fall_sync.sv
module dlc_fall_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic fall
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], async_in};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign fall = prev_q & ~sync_q[STAGES-1];

  a_r9_single_pulse: assert property (@(posedge clk) disable iff (rst)
    fall |=> !fall);
endmodule

// File: rtl/dlc_decade_chain.sv
module dlc_decade_chain
  import dlc_pkg::*;
#(
  parameter int NUM_DIGITS = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        clr_n,
  input  logic                        step,
  output logic [NUM_DIGITS*DIGIT_W-1:0] count_q
);
  localparam int W = NUM_DIGITS * DIGIT_W;

  logic [NUM_DIGITS:0] carry;
  logic [W-1:0]        count_d;

  assign carry[0] = step;

  for (genvar k = 0; k < NUM_DIGITS; k++) begin : g_dec
    digit_t cur;
    assign cur = count_q[k*DIGIT_W +: DIGIT_W];
    assign carry[k+1] = carry[k] & (cur == DIGIT_MAX);
    always_comb begin
      if (!carry[k])              count_d[k*DIGIT_W +: DIGIT_W] = cur;
      else if (cur == DIGIT_MAX)  count_d[k*DIGIT_W +: DIGIT_W] = '0;
      else                        count_d[k*DIGIT_W +: DIGIT_W] = cur + 4'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !clr_n) count_q <= '0;
    else               count_q <= count_d;
  end

  a_r4_clear_wins: assert property (@(posedge clk) disable iff (rst)
    !clr_n |=> count_q == '0);
  a_r9_idle_holds: assert property (@(posedge clk) disable iff (rst)
    (clr_n && !step) |=> $stable(count_q));
  a_r2_step_moves: assert property (@(posedge clk) disable iff (rst)
    (clr_n && step) |=> !$stable(count_q));
endmodule

// File: rtl/decade_latch_counter.sv
module decade_latch_counter
  import dlc_pkg::*;
#(
  parameter int NUM_DIGITS  = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          cnt_in,
  input  logic                          clr_n,
  input  logic                          load_n,
  input  logic                          ovf_in,
  output logic [NUM_DIGITS*DIGIT_W-1:0] snap_bcd,
  output logic                          snap_ovf,
  output logic [2:0]                    top_msb
);
  localparam int W      = NUM_DIGITS * DIGIT_W;
  localparam int TAP_LO = NUM_DIGITS - 3;

  logic         cnt_fall, ovf_fall, ovf_flag;
  logic [W-1:0] count_q;

  dlc_fall_sync #(.STAGES(SYNC_STAGES)) u_cnt_sync (
    .clk(clk), .rst(rst), .async_in(cnt_in), .fall(cnt_fall));

  dlc_fall_sync #(.STAGES(SYNC_STAGES)) u_ovf_sync (
    .clk(clk), .rst(rst), .async_in(ovf_in), .fall(ovf_fall));

  dlc_decade_chain #(.NUM_DIGITS(NUM_DIGITS)) u_chain (
    .clk(clk), .rst(rst), .clr_n(clr_n), .step(cnt_fall), .count_q(count_q));

  always_ff @(posedge clk) begin
    if (rst || !clr_n) ovf_flag <= 1'b0;
    else if (ovf_fall) ovf_flag <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      snap_bcd <= '0;
      snap_ovf <= 1'b0;
    end else if (!load_n) begin
      snap_bcd <= count_q;
      snap_ovf <= ovf_flag;
    end
  end

  for (genvar t = 0; t < 3; t++) begin : g_tap
    assign top_msb[t] = count_q[(TAP_LO + t)*DIGIT_W + DIGIT_W - 1];
  end

  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    load_n |=> $stable(snap_bcd));
  a_r5_copy: assert property (@(posedge clk) disable iff (rst)
    !load_n |=> snap_bcd == $past(count_q));
  a_r6_sticky: assert property (@(posedge clk) disable iff (rst)
    (ovf_flag && clr_n) |=> ovf_flag);
  a_r7_ovf_hold: assert property (@(posedge clk) disable iff (rst)
    load_n |=> $stable(snap_ovf));
endmodule

// File: tb/sim_decade_latch_counter.sv
module sim_decade_latch_counter;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cnt0 = 1'b1, cnt1 = 1'b1, clr_n = 1'b1, load_n = 1'b1, ovf = 1'b1;
  logic [31:0] bcd0;
  logic [11:0] bcd1;
  logic        sov0, sov1;
  logic [2:0]  tap0, tap1;
  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  decade_latch_counter u0 (.clk(clk), .rst(rst), .cnt_in(cnt0), .clr_n(clr_n),
    .load_n(load_n), .ovf_in(ovf), .snap_bcd(bcd0), .snap_ovf(sov0), .top_msb(tap0));
  decade_latch_counter #(.NUM_DIGITS(3)) u1 (.clk(clk), .rst(rst), .cnt_in(cnt1),
    .clr_n(clr_n), .load_n(load_n), .ovf_in(1'b1), .snap_bcd(bcd1), .snap_ovf(sov1),
    .top_msb(tap1));

  function automatic logic [31:0] to_bcd(int v);
    logic [31:0] r = '0;
    for (int k = 0; k < 8; k++) begin
      r[k*4 +: 4] = 4'(v % 10);
      v = v / 10;
    end
    return r;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pulse(bit sel, int low_cycles);
    @(negedge clk);
    if (sel) cnt1 = 1'b0; else cnt0 = 1'b0;
    repeat (low_cycles) @(negedge clk);
    if (sel) cnt1 = 1'b1; else cnt0 = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic snap();
    @(negedge clk) load_n = 1'b0;
    @(negedge clk) load_n = 1'b1;
  endtask

  task automatic do_clear();
    @(negedge clk) clr_n = 1'b0;
    @(negedge clk) clr_n = 1'b1;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 snap", bcd0, 32'h0);
    chk("R1 ovf", {31'b0, sov0}, 32'h0);
    chk("R1 taps", {29'b0, tap0}, 32'h0);
  endtask

  task automatic t_count();
    pulse(0, 3); snap();
    chk("R2 one", bcd0, to_bcd(1));
    for (int i = 0; i < 6; i++) pulse(0, 3);
    snap(); chk("R2 seven", bcd0, to_bcd(7));
    for (int i = 0; i < 5; i++) pulse(0, 3);
    snap(); chk("R3 carry 12", bcd0, to_bcd(12));
    for (int i = 0; i < 88; i++) pulse(0, 3);
    snap(); chk("R3 carry 100", bcd0, to_bcd(100));
  endtask

  task automatic t_long_low();
    pulse(0, 40); snap();
    chk("R9 long low once", bcd0, to_bcd(101));
  endtask

  task automatic t_hold();
    pulse(0, 3); pulse(0, 3);
    chk("R5 held", bcd0, to_bcd(101));
    snap(); chk("R5 copy", bcd0, to_bcd(103));
  endtask

  task automatic t_coincide();
    @(negedge clk) cnt0 = 1'b0;
    @(negedge clk);
    @(negedge clk) load_n = 1'b0;
    @(negedge clk) load_n = 1'b1;
    chk("R10 pre-increment", bcd0, to_bcd(103));
    cnt0 = 1'b1; repeat (3) @(negedge clk);
    snap(); chk("R10 after", bcd0, to_bcd(104));
  endtask

  task automatic t_clear();
    @(negedge clk) cnt0 = 1'b0;
    @(negedge clk);
    @(negedge clk) clr_n = 1'b0;
    @(negedge clk) clr_n = 1'b1;
    cnt0 = 1'b1; repeat (3) @(negedge clk);
    snap(); chk("R4 clear wins", bcd0, to_bcd(0));
  endtask

  task automatic t_overflow();
    @(negedge clk) ovf = 1'b0;
    repeat (4) @(negedge clk);
    chk("R7 not yet", {31'b0, sov0}, 32'h0);
    snap(); chk("R6 set", {31'b0, sov0}, 32'h1);
    ovf = 1'b1; repeat (3) @(negedge clk);
    @(negedge clk) ovf = 1'b0;
    repeat (4) @(negedge clk); ovf = 1'b1; repeat (3) @(negedge clk);
    snap(); chk("R6 sticky", {31'b0, sov0}, 32'h1);
    do_clear();
    chk("R7 hold after clear", {31'b0, sov0}, 32'h1);
    snap(); chk("R6 cleared", {31'b0, sov0}, 32'h0);
  endtask

  task automatic t_wrap();
    for (int i = 0; i < 800; i++) pulse(1, 2);
    @(negedge clk);
    chk("R8 taps 800", {29'b0, tap1}, 32'h4);
    for (int i = 0; i < 199; i++) pulse(1, 2);
    chk("R8 taps 999", {29'b0, tap1}, 32'h7);
    snap(); chk("R3 at 999", {20'b0, bcd1}, 32'h999);
    pulse(1, 2); snap();
    chk("R3 wrap", {20'b0, bcd1}, 32'h000);
  endtask

  initial begin
    fork
      begin
        t_reset(); t_count(); t_long_low(); t_hold(); t_coincide();
        t_clear(); t_overflow(); t_wrap();
      end
      begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule